// File: doc/BRIEF.md
# Packed Signed Word Multiplier

This block multiplies four pairs of signed 16-bit lanes taken from two 64-bit operands. It returns, as selected by a 2-bit operation code, either the low 16 bits of each 32-bit product, the high 16 bits of each product, or the sums of neighbouring product pairs packed as two 32-bit lanes. It sits in a vector execution unit between operand read and writeback. Both of those steps are outside this block.

The datapath has two register stages. The first stage registers the four full products with the operation code and a valid bit. The second stage registers the formatted 64-bit result and its valid bit. An operation can be issued every cycle, and each one comes out two cycles later in issue order.

Operation codes: `00` low half, `01` high half, `10` pairwise multiply-add, `11` reserved. The pipeline has no control states. Each stage holds a single valid flag, which moves from idle to busy when an operation enters and from busy to idle when a cycle passes with no issue.

Top module: `packed_word_mul`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_result` is all zeros until the first issued operation arrives.
- R2: An operation sampled with `in_valid` high at clock edge k appears on `out_result`, with `out_valid` high, after edge k+2. `out_valid` is 0 after edge k+1 and, if nothing else was issued, after edge k+3.
- R3: Operations issued on consecutive cycles come out on consecutive cycles, in issue order, each with its own correct result.
- R4: With op `00`, bits [16i+15:16i] of the result hold the low 16 bits of the signed product of lane i of `in_a` and lane i of `in_b`, for i = 0 to 3.
- R5: With op `01`, bits [16i+15:16i] of the result hold bits [31:16] of the signed product of lane i of the two operands.
- R6: With op `10`, result bits [31:0] hold product0 + product1 and bits [63:32] hold product2 + product3. Each sum is a signed 32-bit value.
- R7: Multiply-add sums wrap modulo 2^32. When all four inputs of a pair are -32768 (0x8000), that doubleword is 0x80000000.
- R8: With op `11`, the result is all zeros and `out_valid` still follows R2.
- R9: In a cycle where no operation reaches the output stage, `out_valid` is 0 and `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operands on this cycle |
| in_op | input | 2 | Operation code: 00 low, 01 high, 10 multiply-add, 11 reserved |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| out_result | output | 64 | Formatted result |

## Verification
The bench uses negative lanes and mixed-sign pairs. A design that multiplied unsigned values would produce wrong high halves and wrong multiply-add sums for those inputs. The all-0x8000 input drives the one case where a pair sum overflows; a design that saturated or widened the sum would not return 0x80000000. Back-to-back issues followed by an idle gap would expose a valid bit that does not move with its data, or an output that is not held. The bench also checks that `out_valid` is low one and three cycles after a single issue, which would expose a design with one stage or three.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic [1:0] {
        OP_LOW  = 2'b00,
        OP_HIGH = 2'b01,
        OP_MADD = 2'b10,
        OP_NONE = 2'b11
    } pmul_op_e;

endpackage

// File: rtl/pmul_lane_mult.sv
module pmul_lane_mult #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0]   lane_a,
    input  logic [LANE_W-1:0]   lane_b,
    output logic [2*LANE_W-1:0] lane_prod
);
    localparam int PROD_W = 2 * LANE_W;

    logic signed [PROD_W-1:0] ext_a;
    logic signed [PROD_W-1:0] ext_b;

    always_comb begin
        ext_a     = {{LANE_W{lane_a[LANE_W-1]}}, lane_a};
        ext_b     = {{LANE_W{lane_b[LANE_W-1]}}, lane_b};
        lane_prod = ext_a * ext_b;
    end
endmodule

// File: rtl/pmul_stage1.sv
module pmul_stage1
    import pmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue_valid,
    input  pmul_op_e                     issue_op,
    input  logic [LANES*LANE_W-1:0]      opnd_a,
    input  logic [LANES*LANE_W-1:0]      opnd_b,
    output logic                         s1_valid,
    output pmul_op_e                     s1_op,
    output logic [LANES*2*LANE_W-1:0]    s1_prod
);
    localparam int PROD_W = 2 * LANE_W;

    logic [LANES*PROD_W-1:0] prod_comb;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pmul_lane_mult #(.LANE_W(LANE_W)) u_mult (
            .lane_a    (opnd_a[i*LANE_W +: LANE_W]),
            .lane_b    (opnd_b[i*LANE_W +: LANE_W]),
            .lane_prod (prod_comb[i*PROD_W +: PROD_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_NONE;
            s1_prod  <= '0;
        end else begin
            s1_valid <= issue_valid;
            if (issue_valid) begin
                s1_op   <= issue_op;
                s1_prod <= prod_comb;
            end
        end
    end
endmodule

// File: rtl/pmul_format.sv
module pmul_format
    import pmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  pmul_op_e                  fmt_op,
    input  logic [LANES*2*LANE_W-1:0] fmt_prod,
    output logic [LANES*LANE_W-1:0]   fmt_result
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int PAIRS  = LANES / 2;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] low_word;
    logic [DATA_W-1:0] high_word;
    logic [DATA_W-1:0] pair_word;

    for (genvar i = 0; i < LANES; i++) begin : g_half
        assign low_word[i*LANE_W +: LANE_W]  = fmt_prod[i*PROD_W +: LANE_W];
        assign high_word[i*LANE_W +: LANE_W] = fmt_prod[i*PROD_W + LANE_W +: LANE_W];
    end

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        assign pair_word[j*PROD_W +: PROD_W] =
            fmt_prod[(2*j)*PROD_W +: PROD_W] + fmt_prod[(2*j+1)*PROD_W +: PROD_W];
    end

    always_comb begin
        unique case (fmt_op)
            OP_LOW:  fmt_result = low_word;
            OP_HIGH: fmt_result = high_word;
            OP_MADD: fmt_result = pair_word;
            default: fmt_result = '0;
        endcase
    end
endmodule

// File: rtl/packed_word_mul.sv
module packed_word_mul
    import pmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                in_op,
    input  logic [LANES*LANE_W-1:0]   in_a,
    input  logic [LANES*LANE_W-1:0]   in_b,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   out_result
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int DATA_W = LANES * LANE_W;

    logic                    s1_valid;
    pmul_op_e                s1_op;
    logic [LANES*PROD_W-1:0] s1_prod;
    logic [DATA_W-1:0]       fmt_result;

    pmul_stage1 #(.LANE_W(LANE_W), .LANES(LANES)) u_stage1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (in_valid),
        .issue_op    (pmul_op_e'(in_op)),
        .opnd_a      (in_a),
        .opnd_b      (in_b),
        .s1_valid    (s1_valid),
        .s1_op       (s1_op),
        .s1_prod     (s1_prod)
    );

    pmul_format #(.LANE_W(LANE_W), .LANES(LANES)) u_format (
        .fmt_op     (s1_op),
        .fmt_prod   (s1_prod),
        .fmt_result (fmt_result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_result <= fmt_result;
            end
        end
    end

    // R2: output strobe follows the first-stage strobe by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(s1_valid));

    // R4: low-half lane 0 equals the low bits of the registered product
    a_r4_low_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_op) == OP_LOW) |->
        out_result[LANE_W-1:0] == $past(s1_prod[LANE_W-1:0]));

    // R5: high-half top lane equals the upper bits of the last product
    a_r5_high_top: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_op) == OP_HIGH) |->
        out_result[DATA_W-1 -: LANE_W] == $past(s1_prod[LANES*PROD_W-1 -: LANE_W]));

    // R6: multiply-add doubleword 0 is the wrapped sum of products 0 and 1
    a_r6_madd_dw0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_op) == OP_MADD) |->
        out_result[PROD_W-1:0] ==
        PROD_W'($past(s1_prod[PROD_W-1:0]) + $past(s1_prod[2*PROD_W-1:PROD_W])));

    // R8: reserved code yields zero
    a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_op) == OP_NONE) |-> out_result == '0);

    // R9: result held when nothing arrives
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s1_valid) |-> $stable(out_result));
endmodule

// File: tb/test_packed_word_mul.sv
`timescale 1ns/1ps
module test_packed_word_mul;

    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    packed_word_mul i_packed_word_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    localparam logic [63:0] VA [NVEC] = '{
        64'h0003_0002_FFFF_0005, 64'h7FFF_8000_1234_FFFE, 64'h0010_FFF0_0100_0007,
        64'h8000_7FFF_ABCD_0001, 64'h0001_0002_0003_0004, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h4000_C000_00FF_FF00, 64'h1111_2222_3333_4444, 64'h0000_0000_0000_0000,
        64'hFFFE_0005_8001_7FFF
    };
    localparam logic [63:0] VB [NVEC] = '{
        64'h0004_FFFD_0006_0007, 64'h7FFF_7FFF_0010_FFFE, 64'hFFFF_0020_FF00_0009,
        64'h8000_8000_0002_FFFF, 64'h0005_0006_0007_0008, 64'h0001_FFFF_0002_FFFE,
        64'h4000_4000_0100_0100, 64'hF000_0F00_00F0_000F, 64'h1234_5678_9ABC_DEF0,
        64'h0003_FFFB_8001_8000
    };
    localparam logic [1:0] VOP [NVEC] = '{
        2'b00, 2'b01, 2'b10, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10, 2'b11, 2'b10
    };

    function automatic logic [63:0] ref_model(input logic [63:0] a,
                                              input logic [63:0] b,
                                              input logic [1:0]  op);
        logic signed [31:0] p [4];
        logic [63:0] r;
        for (int i = 0; i < 4; i++) begin
            p[i] = $signed({{16{a[16*i+15]}}, a[16*i +: 16]}) *
                   $signed({{16{b[16*i+15]}}, b[16*i +: 16]});
        end
        r = '0;
        case (op)
            2'b00: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
            2'b01: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
            2'b10: begin
                r[31:0]  = p[0] + p[1];
                r[63:32] = p[2] + p[3];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] op,
                         input logic [63:0] a, input logic [63:0] b);
        in_valid = v;
        in_op    = op;
        in_a     = a;
        in_b     = b;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 result in reset", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 result after reset", out_result, 64'd0);

        // R3/R4/R5/R6/R8: table streamed back to back
        for (int i = 0; i < NVEC + 2; i++) begin
            if (i < NVEC) issue(1'b1, VOP[i], VA[i], VB[i]);
            else          issue(1'b0, 2'b00, '0, '0);
            if (i >= 2) begin
                check("R3 stream valid", {63'd0, out_valid}, 64'd1);
                check($sformatf("R3 R4 R5 R6 R8 vector %0d op %0d", i-2, VOP[i-2]),
                      out_result, ref_model(VA[i-2], VB[i-2], VOP[i-2]));
            end
            @(negedge clk);
        end

        // R9: idle cycles leave result held and valid low
        held = ref_model(VA[NVEC-1], VB[NVEC-1], VOP[NVEC-1]);
        repeat (2) @(negedge clk);
        check("R9 valid idle", {63'd0, out_valid}, 64'd0);
        check("R9 result held", out_result, held);
        issue(1'b0, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_1234_1234_1234);
        @(negedge clk);
        @(negedge clk);
        check("R9 non-issued operands ignored", out_result, held);

        // R2: single issue latency
        issue(1'b1, 2'b01, 64'hFFF0_0020_8000_0003, 64'h0100_0300_0002_FFFD);
        @(negedge clk);
        issue(1'b0, 2'b00, '0, '0);
        check("R2 valid after one edge", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R2 valid after two edges", {63'd0, out_valid}, 64'd1);
        check("R2 R5 result", out_result,
              ref_model(64'hFFF0_0020_8000_0003, 64'h0100_0300_0002_FFFD, 2'b01));
        @(negedge clk);
        check("R2 valid after three edges", {63'd0, out_valid}, 64'd0);

        // R7: overflow wrap in both doublewords
        issue(1'b1, 2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        @(negedge clk);
        issue(1'b1, 2'b00, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        @(negedge clk);
        issue(1'b1, 2'b01, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        check("R7 madd wrap", out_result, 64'h8000_0000_8000_0000);
        @(negedge clk);
        issue(1'b1, 2'b11, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111);
        check("R4 low of 2^30", out_result, 64'h0000_0000_0000_0000);
        @(negedge clk);
        issue(1'b0, 2'b00, '0, '0);
        check("R5 high of 2^30", out_result, 64'h4000_4000_4000_4000);
        @(negedge clk);
        check("R8 reserved zero", out_result, 64'd0);
        check("R8 reserved valid", {63'd0, out_valid}, 64'd1);

        // R1: reset mid-stream clears output
        issue(1'b1, 2'b00, 64'h0001_0001_0001_0001, 64'h0002_0002_0002_0002);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        issue(1'b0, 2'b00, '0, '0);
        @(negedge clk);
        check("R1 reset clears result", out_result, 64'd0);
        check("R1 reset clears valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 no stale valid", {63'd0, out_valid}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule